// File: doc/BRIEF.md
# Saturating Word-to-Byte Pack Unit

This block narrows two 128-bit vectors into one 128-bit vector. Each input vector holds eight signed 16-bit lanes. Every lane is clamped to the unsigned byte range: negative values become zero, values above 255 become 255, and values in range keep their low eight bits. The sixteen resulting bytes form one output vector.

The bytes from the first operand fill the low half of the result. The bytes from the second operand fill the high half. Lane order is kept, so the lowest input lane lands in the lowest byte of its half.

A caller presents both operands with a valid strobe. Exactly one cycle later the block shows the packed result with a valid flag. A two-state controller tracks whether a result is being presented. The controller has two states, `ST_IDLE` and `ST_EMIT`, and four transitions:
- `ST_IDLE` to `ST_EMIT` when `in_valid` is high.
- `ST_EMIT` to `ST_EMIT` when inputs arrive back to back.
- `ST_EMIT` to `ST_IDLE` when `in_valid` is low.
- `ST_IDLE` to `ST_IDLE` when no input arrives.

Reset is synchronous. The block applies no backpressure.

Top module: `sat_pack_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` becomes 0 and `out_data` becomes all zeros after that edge.
- R2: An input lane whose bit 15 is 1 (a negative two's-complement value) yields output byte 0x00.
- R3: An input lane with bit 15 clear and any of bits 14:8 set (a value from 256 to 32767) yields output byte 0xFF.
- R4: An input lane with bits 15:8 all zero (a value from 0 to 255) yields its bits 7:0 unchanged.
- R5: Bytes from `op_a` occupy `out_data[63:0]`, and bytes from `op_b` occupy `out_data[127:64]`.
- R6: Within each half, source lane n (bits 16n+15:16n) maps to byte n of that half (bits 8n+7:8n relative to the half).
- R7: `out_valid` is 1 in the cycle after a clock edge at which `in_valid` was 1, and 0 in the cycle after an edge at which `in_valid` was 0. This holds for back-to-back inputs too.
- R8: When `in_valid` is 0 at an edge, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 128 | First source: eight signed 16-bit lanes |
| op_b | input | 128 | Second source: eight signed 16-bit lanes |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Sixteen saturated unsigned bytes |

## Verification
The hardest case to reach is the exact boundary values sitting in every lane position of both operands. Random 16-bit words almost never land on 0x00FF, 0x0100, 0x7FFF, 0x8000, 0xFFFF or 0x0000. Directed vectors therefore place all six boundary values in rotated lane positions of each operand. They are mixed with random vectors biased toward small magnitudes.

Back-to-back accepts followed by idle gaps drive every controller transition. The idle gaps show that the held result does not change.

// File: rtl/sat_pack_pkg.sv
package sat_pack_pkg;
    parameter int LANE_W   = 16;
    parameter int BYTE_W   = 8;
    parameter int LANES    = 8;
    localparam int SRC_W   = LANES * LANE_W;
    localparam int HALF_W  = LANES * BYTE_W;
    localparam int RES_W   = 2 * HALF_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } pk_state_e;
endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  lane_in,
    output logic [OUT_W-1:0] lane_out
);
    logic is_neg;
    logic is_over;

    always_comb begin
        is_neg  = lane_in[IN_W-1];
        is_over = |lane_in[IN_W-2:OUT_W];
        if (is_neg)
            lane_out = '0;
        else if (is_over)
            lane_out = '1;
        else
            lane_out = lane_in[OUT_W-1:0];
    end
endmodule

// File: rtl/sat_half.sv
module sat_half #(
    parameter int LANES = 8,
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic [LANES*IN_W-1:0]  src,
    output logic [LANES*OUT_W-1:0] half_out
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        sat_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
            .lane_in  (src[n*IN_W +: IN_W]),
            .lane_out (half_out[n*OUT_W +: OUT_W])
        );
    end
endmodule

// File: rtl/sat_pack_unit.sv
module sat_pack_unit
    import sat_pack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] op_a,
    input  logic [SRC_W-1:0] op_b,
    output logic             out_valid,
    output logic [RES_W-1:0] out_data
);
    pk_state_e         state_q;
    pk_state_e         state_d;
    logic [HALF_W-1:0] lo_bytes;
    logic [HALF_W-1:0] hi_bytes;

    sat_half #(.LANES(LANES), .IN_W(LANE_W), .OUT_W(BYTE_W)) u_lo (
        .src      (op_a),
        .half_out (lo_bytes)
    );

    sat_half #(.LANES(LANES), .IN_W(LANE_W), .OUT_W(BYTE_W)) u_hi (
        .src      (op_b),
        .half_out (hi_bytes)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_data <= '0;
        else if (in_valid)
            out_data <= {hi_bytes, lo_bytes};
    end

    always_comb begin
        out_valid = (state_q == ST_EMIT);
    end
endmodule

// File: rtl/sat_pack_unit_chk.sv
module sat_pack_unit_chk
    import sat_pack_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [SRC_W-1:0] op_a,
    input logic [SRC_W-1:0] op_b,
    input logic             out_valid,
    input logic [RES_W-1:0] out_data
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R7
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_data)); // R8

    for (genvar n = 0; n < LANES; n++) begin : g_chk
        AST_A_NEG: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_a[n*LANE_W+LANE_W-1]) |=> out_data[n*BYTE_W +: BYTE_W] == '0); // R2 R5 R6
        AST_B_NEG: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_b[n*LANE_W+LANE_W-1]) |=> out_data[(LANES+n)*BYTE_W +: BYTE_W] == '0); // R2 R5 R6
        AST_A_OVER: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !op_a[n*LANE_W+LANE_W-1] && |op_a[n*LANE_W+BYTE_W +: LANE_W-BYTE_W-1])
            |=> out_data[n*BYTE_W +: BYTE_W] == '1); // R3
        AST_B_OVER: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !op_b[n*LANE_W+LANE_W-1] && |op_b[n*LANE_W+BYTE_W +: LANE_W-BYTE_W-1])
            |=> out_data[(LANES+n)*BYTE_W +: BYTE_W] == '1); // R3
        AST_A_PASS: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_a[n*LANE_W+BYTE_W +: LANE_W-BYTE_W] == '0)
            |=> out_data[n*BYTE_W +: BYTE_W] == $past(op_a[n*LANE_W +: BYTE_W])); // R4
        AST_B_PASS: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_b[n*LANE_W+BYTE_W +: LANE_W-BYTE_W] == '0)
            |=> out_data[(LANES+n)*BYTE_W +: BYTE_W] == $past(op_b[n*LANE_W +: BYTE_W])); // R4
    end
endmodule

bind sat_pack_unit sat_pack_unit_chk u_chk (.*);

// File: tb/sat_pack_unit_bench.sv
module sat_pack_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int compared = 0;
    int mismatched = 0;
    logic [127:0] last_exp = '0;
    bit done = 1'b0;

    sat_pack_unit u_sat_pack_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] sat8(input logic [15:0] w);
        int v;
        v = $signed(w);
        if (v < 0) return 8'h00;
        if (v > 255) return 8'hFF;
        return w[7:0];
    endfunction

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        for (int n = 0; n < 8; n++) begin
            r[8*n +: 8]      = sat8(a[16*n +: 16]);
            r[64 + 8*n +: 8] = sat8(b[16*n +: 16]);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one accept at a negedge, then sample at the next negedge.
    task automatic send(input logic [127:0] a, input logic [127:0] b, input bit keep_valid);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        last_exp = model(a, b);
        @(negedge clk);
        if (!keep_valid) in_valid = 1'b0;
        check("R7 valid", {127'd0, out_valid}, 128'd1);
        check("R2 R3 R4 R5 R6 data", out_data, last_exp);
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        op_a = {$urandom, $urandom, $urandom, $urandom};
        op_b = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        check("R7 idle valid", {127'd0, out_valid}, 128'd0);
        check("R8 hold", out_data, last_exp);
    endtask

    function automatic logic [15:0] rnd_lane();
        logic [15:0] w;
        w = 16'($urandom);
        case ($urandom % 4)
            0: w = {8'h00, w[7:0]};
            1: w = {8'hFF, w[7:0]};
            2: w = {7'h00, w[8:0]};
            default: ;
        endcase
        return w;
    endfunction

    initial begin
        #100000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [15:0] corner [8];
        logic [127:0] a;
        logic [127:0] b;
        void'($urandom(32'd1234));
        corner[0] = 16'h7FFF; corner[1] = 16'h8000; corner[2] = 16'h0100; corner[3] = 16'h00FF;
        corner[4] = 16'hFFFF; corner[5] = 16'h0000; corner[6] = 16'h0080; corner[7] = 16'h0101;

        repeat (3) @(negedge clk);
        check("R1 reset valid", {127'd0, out_valid}, 128'd0);
        check("R1 reset data", out_data, 128'd0);
        rst = 1'b0;

        // Boundary values rotated through every lane of both operands (R2 R3 R4 R5 R6).
        for (int r = 0; r < 8; r++) begin
            for (int n = 0; n < 8; n++) begin
                a[16*n +: 16] = corner[(n + r) % 8];
                b[16*n +: 16] = corner[(n + r + 3) % 8];
            end
            send(a, b, 1'b0);
        end

        // Lane order: distinct in-range values reveal any swap (R6), halves distinct (R5).
        for (int n = 0; n < 8; n++) begin
            a[16*n +: 16] = 16'(n + 1);
            b[16*n +: 16] = 16'(8'hA0 + n);
        end
        send(a, b, 1'b0);
        idle_check();

        // Back-to-back accepts then idle gaps (R7 R8).
        for (int it = 0; it < 200; it++) begin
            for (int n = 0; n < 8; n++) begin
                a[16*n +: 16] = rnd_lane();
                b[16*n +: 16] = rnd_lane();
            end
            send(a, b, ($urandom % 3) != 0);
            if (($urandom % 4) == 0) idle_check();
        end
        idle_check();

        // Reset in the middle of operation clears outputs (R1).
        send({8{16'h0042}}, {8{16'h0123}}, 1'b1);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R1 mid reset valid", {127'd0, out_valid}, 128'd0);
        check("R1 mid reset data", out_data, 128'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule